// File: doc/BRIEF.md
# I2C Controller Byte Transmitter

This block is the transmit half of an I2C controller. Software places one byte in a data register and then writes a control word that says whether a START comes before the byte, whether a STOP follows it, whether arbitration loss may raise the interrupt, and a go bit that launches the transfer. The block drives open-drain SCL and SDA through active-low pull controls. It shifts the byte out most significant bit first, samples the acknowledge in a ninth clock slot, and then reports that the data register may be reloaded.

A transaction starts with a byte that holds the target address, with the read/not-write flag as its LSB. One or more data bytes follow. The last data byte is launched with the STOP qualifier. If another controller wins the bus while the address byte is going out, the block lets go of both lines. It waits until a STOP shows that the bus is free, and then sends the START and the address again without help from software.

SCL timing comes from a divider input. Each bit slot has four quarters of `clk_div` system clocks each: two quarters with SCL low and two with SCL high. SDA is changed only at the middle of the low half. The exceptions are the START and STOP sequences.

Top module: `i2c_master_byte_tx`

## Requirements
- R1: After reset, both line pulls are off, all status outputs and `irq` are 0, and the control readback is 0.
- R2: A write of the control register (`reg_addr`=1) with bit 0 (start) and bit 3 (go) set, while the bus is free, produces a START: SDA falls while SCL is high. The data register byte (`reg_addr`=0) is then sent MSB first, with each bit valid on the rising SCL edge.
- R3: During bit slots, every SCL high phase and every SCL low phase between bits lasts exactly 2*`clk_div` clock cycles.
- R4: SDA changes only while SCL is low, except inside START and STOP. A two-byte transaction ending in STOP shows exactly one START and one STOP on the bus.
- R5: At the end of each acknowledge slot, `st_tx_empty` becomes 1 with `st_busy`=1. Control bit 3 (go) reads back 0. `st_rnw` shows the LSB of the last address byte, which is 0 for a write.
- R6: `st_nak` holds the SDA level sampled in the acknowledge slot: 0 when the target pulled it low, 1 when nobody did.
- R7: A write to the status register (`reg_addr`=2) clears `st_tx_empty` where data bit 0 is 1 and `st_arb_lost` where data bit 1 is 1. Bits written as 0 leave the flags unchanged.
- R8: With control bit 1 (stop) set, a STOP follows the acknowledge slot. `st_tx_empty` is already 1 while the STOP is being sent, with `st_busy`=1. `st_busy` falls to 0 once the STOP has completed.
- R9: If SDA reads low at the end of a high phase in which the block released it during a data or address bit, `st_arb_lost` becomes 1 and both pulls are switched off at once.
- R10: After arbitration is lost during the address byte, the block waits for a STOP on the bus. It then sends a START and the same address byte again, and a complete byte reaches the target.
- R11: `irq` is 1 whenever `st_tx_empty` is 1, or when `st_arb_lost` is 1 and control bit 2 (arbitration-loss interrupt enable) is set. Otherwise it is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clk_div | input | DIV_W | Length in clocks of one quarter of an SCL period |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 data, 1 control, 2 status clear |
| reg_wdata | input | 8 | Register write data |
| ctrl_out | output | 4 | Control readback: [0] start, [1] stop, [2] arbitration-loss irq enable, [3] go |
| st_tx_empty | output | 1 | Data register may be reloaded |
| st_arb_lost | output | 1 | Arbitration was lost |
| st_busy | output | 1 | Engine is not idle |
| st_nak | output | 1 | Last acknowledge slot read high |
| st_rnw | output | 1 | LSB of the last address byte sent |
| irq | output | 1 | Interrupt request |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level |
| scl_low | output | 1 | Pull SCL low when 1 |
| sda_low | output | 1 | Pull SDA low when 1 |

## Verification
The main function is driven with four patterns: an acknowledged address byte followed by a data byte with STOP, a transaction in which the target never acknowledges, and two address attempts in which a rival controller pulls SDA low on the first bit, once with the loss interrupt masked and once with it enabled. The clean transaction checks byte content, the phase lengths and the count of START and STOP events. The unacknowledged run separates a sampled acknowledge from a hard-wired one. The contested runs show release on loss, retry only after a STOP, and the interrupt mask working in both positions.

// File: rtl/i2ctx_pkg.sv
package i2ctx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_BIT,
    ST_HOLD,
    ST_STOP,
    ST_ARB
  } eng_state_t;

  localparam int unsigned CTL_START = 0;
  localparam int unsigned CTL_STOP  = 1;
  localparam int unsigned CTL_ALIE  = 2;
  localparam int unsigned CTL_GO    = 3;
  localparam int unsigned CTL_W     = 4;

  localparam logic [1:0] RA_DATA = 2'd0;
  localparam logic [1:0] RA_CTRL = 2'd1;
  localparam logic [1:0] RA_STAT = 2'd2;

  localparam logic [3:0] ACK_IDX = 4'd8;

  // pull level for slot idx of a byte; the acknowledge slot is always released
  function automatic logic bit_pulls_low(logic [7:0] b, logic [3:0] idx);
    if (idx >= ACK_IDX) return 1'b0;
    return ~b[3'd7 - idx[2:0]];
  endfunction

  function automatic logic irq_level(logic te, logic al, logic alie);
    return te | (al & alie);
  endfunction

endpackage

// File: rtl/i2ctx_qtr_timer.sv
module i2ctx_qtr_timer #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);

  logic [DIV_W-1:0] cnt;

  function automatic logic [DIV_W-1:0] last_count(logic [DIV_W-1:0] d);
    return (d == '0) ? '0 : d - 1'b1;
  endfunction

  assign tick = run && (cnt == last_count(div));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (!run) cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/i2ctx_bus_mon.sv
module i2ctx_bus_mon (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_s,
  output logic bus_free
);

  logic [1:0] scl_sy, sda_sy;
  logic       scl_p, sda_p;
  logic       start_evt, stop_evt;

  assign sda_s     = sda_sy[1];
  assign start_evt = scl_sy[1] & scl_p & sda_p & ~sda_sy[1];
  assign stop_evt  = scl_sy[1] & scl_p & ~sda_p & sda_sy[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sy   <= 2'b11;
      sda_sy   <= 2'b11;
      scl_p    <= 1'b1;
      sda_p    <= 1'b1;
      bus_free <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_in};
      sda_sy <= {sda_sy[0], sda_in};
      scl_p  <= scl_sy[1];
      sda_p  <= sda_sy[1];
      if (stop_evt)       bus_free <= 1'b1;
      else if (start_evt) bus_free <= 1'b0;
    end
  end

endmodule

// File: rtl/i2ctx_regs.sv
module i2ctx_regs
  import i2ctx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [1:0]       reg_addr,
  input  logic [7:0]       reg_wdata,
  input  logic             byte_done,
  input  logic             arb_set,
  input  logic             go_clr,
  output logic [7:0]       data_q,
  output logic [CTL_W-1:0] ctrl_q,
  output logic             te,
  output logic             al
);

  logic wr_data, wr_ctrl, wr_stat;

  assign wr_data = reg_wr && (reg_addr == RA_DATA);
  assign wr_ctrl = reg_wr && (reg_addr == RA_CTRL);
  assign wr_stat = reg_wr && (reg_addr == RA_STAT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      ctrl_q <= '0;
      te     <= 1'b0;
      al     <= 1'b0;
    end else begin
      if (wr_data) data_q <= reg_wdata;
      if (wr_ctrl)     ctrl_q <= reg_wdata[CTL_W-1:0];
      else if (go_clr) ctrl_q[CTL_GO] <= 1'b0;
      if (byte_done)                  te <= 1'b1;
      else if (wr_stat && reg_wdata[0]) te <= 1'b0;
      if (arb_set)                    al <= 1'b1;
      else if (wr_stat && reg_wdata[1]) al <= 1'b0;
    end
  end

endmodule

// File: rtl/i2ctx_engine.sv
module i2ctx_engine
  import i2ctx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       req_start,
  input  logic       req_stop,
  input  logic       req_go,
  input  logic [7:0] data_q,
  input  logic       sda_s,
  input  logic       bus_free,
  output logic       run,
  output logic       scl_low,
  output logic       sda_low,
  output logic       busy,
  output logic       nak,
  output logic       rnw,
  output logic       byte_done,
  output logic       arb_set,
  output logic       go_clr,
  output logic       in_data_slot
);

  eng_state_t state;
  logic [1:0] qtr;
  logic [3:0] bit_idx;
  logic [7:0] shift;
  logic       sda_q;
  logic       addr_phase;
  logic       launch_start, launch_data, slot_end, on_ack;

  assign launch_start = req_go && req_start &&
                        (((state == ST_IDLE) && bus_free) || (state == ST_HOLD));
  assign launch_data  = req_go && !req_start && (state == ST_HOLD);
  assign on_ack       = (bit_idx == ACK_IDX);
  assign slot_end     = (state == ST_BIT) && tick && (qtr == 2'd3);
  assign byte_done    = slot_end && on_ack;
  assign arb_set      = slot_end && !on_ack && !sda_q && !sda_s;
  assign go_clr       = byte_done || ((state == ST_ARB) && bus_free && !addr_phase);

  assign run          = (state == ST_START) || (state == ST_BIT) || (state == ST_STOP);
  assign scl_low      = (((state == ST_BIT) || (state == ST_STOP)) && !qtr[1]) ||
                        (state == ST_HOLD);
  assign sda_low      = sda_q;
  assign busy         = (state != ST_IDLE);
  assign in_data_slot = (state == ST_BIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      qtr        <= '0;
      bit_idx    <= '0;
      shift      <= '0;
      sda_q      <= 1'b0;
      addr_phase <= 1'b0;
      nak        <= 1'b0;
      rnw        <= 1'b0;
    end else begin
      case (state)
        ST_IDLE, ST_HOLD: begin
          sda_q <= 1'b0;
          if (launch_start) begin
            state      <= ST_START;
            qtr        <= '0;
            shift      <= data_q;
            rnw        <= data_q[0];
            addr_phase <= 1'b1;
          end else if (launch_data) begin
            state      <= ST_BIT;
            qtr        <= '0;
            bit_idx    <= '0;
            shift      <= data_q;
            addr_phase <= 1'b0;
          end
        end
        ST_START: if (tick) begin
          qtr <= qtr + 2'd1;
          if (qtr == 2'd1) sda_q <= 1'b1;
          if (qtr == 2'd3) begin
            state   <= ST_BIT;
            bit_idx <= '0;
          end
        end
        ST_BIT: if (tick) begin
          qtr <= qtr + 2'd1;
          if (qtr == 2'd0) sda_q <= bit_pulls_low(shift, bit_idx);
          if (qtr == 2'd3) begin
            if (arb_set) begin
              state <= ST_ARB;
              sda_q <= 1'b0;
            end else if (on_ack) begin
              nak   <= sda_s;
              state <= req_stop ? ST_STOP : ST_HOLD;
            end else begin
              bit_idx <= bit_idx + 4'd1;
            end
          end
        end
        ST_STOP: if (tick) begin
          qtr <= qtr + 2'd1;
          if (qtr == 2'd0) sda_q <= 1'b1;
          if (qtr == 2'd2) sda_q <= 1'b0;
          if (qtr == 2'd3) state <= ST_IDLE;
        end
        ST_ARB: begin
          sda_q <= 1'b0;
          if (bus_free) begin
            if (addr_phase) begin
              state <= ST_START;
              qtr   <= '0;
              shift <= data_q;
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/i2c_master_byte_tx.sv
module i2c_master_byte_tx
  import i2ctx_pkg::*;
#(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] clk_div,
  input  logic             reg_wr,
  input  logic [1:0]       reg_addr,
  input  logic [7:0]       reg_wdata,
  output logic [3:0]       ctrl_out,
  output logic             st_tx_empty,
  output logic             st_arb_lost,
  output logic             st_busy,
  output logic             st_nak,
  output logic             st_rnw,
  output logic             irq,
  input  logic             scl_in,
  input  logic             sda_in,
  output logic             scl_low,
  output logic             sda_low
);

  logic [7:0]       data_q;
  logic [CTL_W-1:0] ctrl_q;
  logic             tick, run, sda_s, bus_free;
  logic             byte_done, arb_set, go_clr, in_data_slot;

  i2ctx_regs u_regs (
    .clk, .rst_n, .reg_wr, .reg_addr, .reg_wdata,
    .byte_done, .arb_set, .go_clr,
    .data_q, .ctrl_q, .te(st_tx_empty), .al(st_arb_lost)
  );

  i2ctx_qtr_timer #(.DIV_W(DIV_W)) u_timer (
    .clk, .rst_n, .run, .div(clk_div), .tick
  );

  i2ctx_bus_mon u_mon (
    .clk, .rst_n, .scl_in, .sda_in, .sda_s, .bus_free
  );

  i2ctx_engine u_eng (
    .clk, .rst_n, .tick,
    .req_start(ctrl_q[CTL_START]), .req_stop(ctrl_q[CTL_STOP]), .req_go(ctrl_q[CTL_GO]),
    .data_q, .sda_s, .bus_free,
    .run, .scl_low, .sda_low, .busy(st_busy), .nak(st_nak), .rnw(st_rnw),
    .byte_done, .arb_set, .go_clr, .in_data_slot
  );

  assign ctrl_out = ctrl_q;
  assign irq      = irq_level(st_tx_empty, st_arb_lost, ctrl_q[CTL_ALIE]);

endmodule

// File: rtl/i2c_master_byte_tx_chk.sv
module i2c_master_byte_tx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_wr,
  input logic [1:0] reg_addr,
  input logic       clr_te,
  input logic       go_bit,
  input logic       st_tx_empty,
  input logic       st_arb_lost,
  input logic       st_busy,
  input logic       irq,
  input logic       scl_low,
  input logic       sda_low,
  input logic       byte_done,
  input logic       in_data_slot
);

  assert_idle_released_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !st_busy |-> (!scl_low && !sda_low));

  assert_sda_still_scl_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_data_slot && $past(in_data_slot) && !scl_low && !$past(scl_low)) |-> $stable(sda_low));

  assert_go_cleared_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(st_tx_empty) && !$past(reg_wr)) |-> !go_bit);

  assert_te_with_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_tx_empty) |-> st_busy);

  assert_w1c_te_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd2 && clr_te && !byte_done) |=> !st_tx_empty);

  assert_arb_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_arb_lost) |-> (!scl_low && !sda_low));

  assert_irq_on_te_R11: assert property (@(posedge clk) disable iff (!rst_n)
    st_tx_empty |-> irq);

endmodule

bind i2c_master_byte_tx i2c_master_byte_tx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .clr_te(reg_wdata[0]), .go_bit(ctrl_out[3]),
  .st_tx_empty(st_tx_empty), .st_arb_lost(st_arb_lost), .st_busy(st_busy), .irq(irq),
  .scl_low(scl_low), .sda_low(sda_low), .byte_done(byte_done), .in_data_slot(in_data_slot)
);

// File: tb/test_i2c_master_byte_tx.sv
`timescale 1ns/1ps
module test_i2c_master_byte_tx;

  localparam int DIV = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [3:0] ctrl_out;
  logic       st_tx_empty, st_arb_lost, st_busy, st_nak, st_rnw, irq;
  logic       scl_low, sda_low;
  logic       oth_sda = 1'b0;
  logic       tgt_ack_en = 1'b1;
  logic       tgt_ack = 1'b0;
  wire        scl_line = !scl_low;
  wire        sda_line = !(sda_low | oth_sda | tgt_ack);

  int n_chk = 0, n_fail = 0;
  int n_start = 0, n_stop = 0, n_bytes = 0, bad_hi = 0, bad_lo = 0;
  logic [7:0] rx_last = '0;

  always #2.5 clk = ~clk;

  i2c_master_byte_tx i_i2c_master_byte_tx (
    .clk, .rst_n, .clk_div(8'(DIV)), .reg_wr, .reg_addr, .reg_wdata,
    .ctrl_out, .st_tx_empty, .st_arb_lost, .st_busy, .st_nak, .st_rnw, .irq,
    .scl_in(scl_line), .sda_in(sda_line), .scl_low, .sda_low
  );

  // target model, sampled away from the active edge
  logic       scl_p = 1'b1, sda_p = 1'b1;
  int         nbits = 0, hcnt = 0, lcnt = 0;
  logic [7:0] rx = '0;
  always @(negedge clk) begin
    if (scl_line && scl_p && sda_p && !sda_line) begin n_start++; nbits = 0; end
    if (scl_line && scl_p && !sda_p && sda_line) begin n_stop++; nbits = 0; tgt_ack = 1'b0; end
    if (scl_line && !scl_p) begin
      if (nbits >= 1 && nbits <= 8 && lcnt != 2*DIV) bad_lo++;
      hcnt = 1;
      if (nbits < 8) begin
        rx = {rx[6:0], sda_line};
        nbits++;
        if (nbits == 8) begin rx_last = rx; n_bytes++; end
      end else if (nbits == 8) nbits = 9;
    end else if (!scl_line && scl_p) begin
      if (nbits >= 1 && hcnt != 2*DIV) bad_hi++;
      lcnt = 1;
      if (nbits == 8) tgt_ack = tgt_ack_en;
      else if (nbits == 9) begin tgt_ack = 1'b0; nbits = 0; end
    end else begin
      hcnt++;
      lcnt++;
    end
    scl_p = scl_line;
    sda_p = sda_line;
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic wait_te(input string req);
    bit ok = 0;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (st_tx_empty) begin ok = 1; break; end
    end
    chk(req, "tx_empty reached", int'(ok), 1);
  endtask

  task automatic wait_idle(input string req);
    bit ok = 0;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (!st_busy) begin ok = 1; break; end
    end
    chk(req, "idle reached", int'(ok), 1);
  endtask

  task automatic wait_scl(input logic lvl);
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (scl_line == lvl) break;
    end
  endtask

  task automatic t_reset();
    chk("R1", "scl line", int'(scl_line), 1);
    chk("R1", "sda line", int'(sda_line), 1);
    chk("R1", "status", int'({st_tx_empty, st_arb_lost, st_busy, st_nak, st_rnw, irq}), 0);
    chk("R1", "ctrl", int'(ctrl_out), 0);
  endtask

  task automatic t_clean_write();
    int s0 = n_start, p0 = n_stop, b0 = n_bytes;
    wr(2'd0, 8'hA4);
    wr(2'd1, 8'h09);
    wait_te("R5");
    chk("R2", "address byte on bus", int'(rx_last), 'hA4);
    chk("R5", "busy at tx_empty", int'(st_busy), 1);
    chk("R5", "go self-cleared", int'(ctrl_out[3]), 0);
    chk("R5", "rnw", int'(st_rnw), 0);
    chk("R6", "ack seen", int'(st_nak), 0);
    chk("R11", "irq from tx_empty", int'(irq), 1);
    wr(2'd2, 8'h00);
    chk("R7", "zero write keeps flag", int'(st_tx_empty), 1);
    wr(2'd2, 8'h01);
    chk("R7", "w1c clears flag", int'(st_tx_empty), 0);
    chk("R11", "irq low", int'(irq), 0);
    wr(2'd0, 8'h5A);
    wr(2'd1, 8'h0E);
    wait_te("R8");
    chk("R8", "busy while stop", int'(st_busy), 1);
    wait_idle("R8");
    chk("R2", "data byte on bus", int'(rx_last), 'h5A);
    chk("R2", "byte count", n_bytes - b0, 2);
    chk("R4", "start count", n_start - s0, 1);
    chk("R4", "stop count", n_stop - p0, 1);
    chk("R3", "bad high phases", bad_hi, 0);
    chk("R3", "bad low phases", bad_lo, 0);
    chk("R8", "lines free after stop", int'({scl_line, sda_line}), 3);
    wr(2'd1, 8'h00);
    wr(2'd2, 8'h01);
  endtask

  task automatic t_nak();
    tgt_ack_en = 1'b0;
    wr(2'd0, 8'h3C);
    wr(2'd1, 8'h09);
    wait_te("R6");
    chk("R6", "nak after address", int'(st_nak), 1);
    wr(2'd2, 8'h01);
    wr(2'd0, 8'hC3);
    wr(2'd1, 8'h0A);
    wait_idle("R6");
    chk("R6", "nak after data", int'(st_nak), 1);
    tgt_ack_en = 1'b1;
    wr(2'd1, 8'h00);
    wr(2'd2, 8'h01);
  endtask

  task automatic t_arb(input logic alie);
    int b0 = n_bytes, s0;
    bit ok = 0;
    wr(2'd0, 8'hA0);
    wr(2'd1, alie ? 8'h0D : 8'h09);
    wait_scl(1'b0);
    wait_scl(1'b1);
    oth_sda = 1'b1;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (st_arb_lost) begin ok = 1; break; end
    end
    chk("R9", "loss flagged", int'(ok), 1);
    chk("R9", "pulls off", int'({scl_low, sda_low}), 0);
    chk("R11", "irq on loss vs enable", int'(irq), int'(alie));
    repeat (10) @(negedge clk);
    chk("R10", "waits for free bus", int'(st_tx_empty), 0);
    s0 = n_start;
    oth_sda = 1'b0;
    wait_te("R10");
    chk("R10", "retried address", int'(rx_last), 'hA0);
    chk("R10", "one full byte", n_bytes - b0, 1);
    chk("R10", "fresh start", n_start - s0, 1);
    wr(2'd2, 8'h03);
    chk("R7", "both flags cleared", int'({st_tx_empty, st_arb_lost}), 0);
    wr(2'd0, 8'h11);
    wr(2'd1, 8'h0E);
    wait_idle("R10");
    wr(2'd1, 8'h00);
    wr(2'd2, 8'h01);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_clean_write();
    t_nak();
    t_arb(1'b0);
    t_arb(1'b1);
    repeat (20) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule